// File: doc/BRIEF.md
# Within-Road Duplicate Track Remover

This block filters the track candidates produced for a single road. Candidates arrive as a stream, one per cycle, each carrying a hit identifier for every detector layer, a mask of the layers on which a hit is present, and a fit quality (chi-square style: a smaller value is a better fit). Each new candidate is compared in the same cycle against every candidate still held for the current road. If the two share enough hits, only the better one survives.

A road ends with an end marker. The marker may arrive alone or together with the last candidate. After the marker, the block streams out the surviving candidates in the order in which they arrived, then emits one marker cycle of its own, and then accepts the next road. The buffer starts empty for every road, so candidates from different roads are never compared with each other. The threshold for the number of shared hits is a configuration input.

The control is a two-state machine:
- FILL accepts candidates and judges each one.
- FLUSH drains the survivors oldest-first and then marks the end of the road.

There are three transitions:
- FILL to FLUSH on an accepted end marker.
- FLUSH to FLUSH while survivors remain.
- FLUSH to FILL in the cycle that emits the output marker.

Top module: `trk_dedup`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` and `out_eor` are 0, and `drop_count` is 0.
- R2: The shared-hit count of two candidates counts only the layers on which both have the present bit set and the hit identifiers are equal. Layer `l` uses bits `[l*HIT_W +: HIT_W]` of the hit bus and bit `l` of the present mask. The pair is a duplicate when this count is greater than or equal to `cfg_share_min`.
- R3: A candidate that duplicates no held candidate is kept if a slot is free.
- R4: A candidate whose quality value is strictly lower than that of every held candidate it duplicates evicts all of them and is kept. Evicted candidates are never output.
- R5: A candidate that duplicates a held candidate of equal or lower quality value is discarded. On a tie, the held candidate wins.
- R6: When all `DEPTH` slots are occupied, a non-duplicate candidate is discarded and `drop_count` increases by one, saturating at its maximum. A replacing duplicate is still accepted when the buffer is full.
- R7: The end of a road is handled as follows:
  - In each cycle after the accepted end marker, one survivor is presented with `out_valid`=1, in arrival order.
  - One cycle with `out_eor`=1 and `out_valid`=0 follows the survivors.
  - `in_ready` is 0 from the cycle after the marker through the `out_eor` cycle.
  - Inputs offered while `in_ready` is 0 are ignored.
- R8: A candidate accepted in the same cycle as the end marker belongs to that road and is judged before the flush.
- R9: In FILL, one candidate is accepted every cycle with no gaps. Each candidate is compared against the state left by the candidate accepted in the previous cycle.
- R10: Every road starts with an empty buffer. A marker with no candidates yields a lone `out_eor` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_share_min | input | CNT_W | Shared-hit count at which two candidates are duplicates |
| in_valid | input | 1 | Candidate present on the input |
| in_eor | input | 1 | End-of-road marker |
| in_hit | input | NLAYER*HIT_W | Per-layer hit identifiers |
| in_present | input | NLAYER | Per-layer hit-present mask |
| in_chi | input | QUAL_W | Fit quality, lower is better |
| in_ready | output | 1 | Block is in FILL and takes input |
| out_valid | output | 1 | Surviving candidate on the output |
| out_eor | output | 1 | End-of-road marker on the output |
| out_hit | output | NLAYER*HIT_W | Hit identifiers of the output candidate |
| out_present | output | NLAYER | Present mask of the output candidate |
| out_chi | output | QUAL_W | Quality of the output candidate |
| drop_count | output | OVF_W | Saturating count of candidates lost to a full buffer |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is judging a candidate and ending the road. The bench drives the last candidate of each road together with the end marker. It then checks that this candidate's keep, replace or discard outcome is already reflected in the first flushed output.

The second pair is evicting duplicates and inserting the replacement. The bench builds roads in which one candidate evicts one or two held candidates in a single cycle, and one of these roads does so while the buffer is full. The flushed sequence is compared with the survivors expected in arrival order, so a replacement that lands in a freed slot but is output at its old position is reported.

// File: rtl/trk_dedup_pkg.sv
package trk_dedup_pkg;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_FLUSH = 1'b1
    } dedup_state_e;

endpackage

// File: rtl/trk_dedup_pair.sv
module trk_dedup_pair #(
    parameter int NLAYER = 8,
    parameter int HIT_W  = 6,
    parameter int QUAL_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic                     live,
    input  logic [NLAYER*HIT_W-1:0]  old_hit,
    input  logic [NLAYER-1:0]        old_pres,
    input  logic [QUAL_W-1:0]        old_chi,
    input  logic [NLAYER*HIT_W-1:0]  new_hit,
    input  logic [NLAYER-1:0]        new_pres,
    input  logic [QUAL_W-1:0]        new_chi,
    input  logic [CNT_W-1:0]         share_min,
    output logic                     is_dup,
    output logic                     new_better
);

    logic [CNT_W-1:0] shared;

    // Count layers where both candidates hold the same hit.
    always_comb begin
        shared = '0;
        for (int l = 0; l < NLAYER; l++) begin
            if (old_pres[l] && new_pres[l] &&
                (old_hit[l*HIT_W +: HIT_W] == new_hit[l*HIT_W +: HIT_W])) begin
                shared = shared + CNT_W'(1);
            end
        end
    end

    assign is_dup     = live && (shared >= share_min);
    assign new_better = new_chi < old_chi;

endmodule

// File: rtl/trk_dedup_pick.sv
module trk_dedup_pick #(
    parameter int DEPTH = 4,
    parameter int SEQ_W = 8,
    parameter int IDX_W = 2
) (
    input  logic [DEPTH-1:0]       live,
    input  logic [DEPTH*SEQ_W-1:0] seq_flat,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);

    logic [SEQ_W-1:0] best;

    // Oldest live slot: smallest arrival stamp.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (live[i] && (!any || (seq_flat[i*SEQ_W +: SEQ_W] < best))) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = seq_flat[i*SEQ_W +: SEQ_W];
            end
        end
    end

endmodule

// File: rtl/trk_dedup.sv
module trk_dedup
    import trk_dedup_pkg::*;
#(
    parameter int NLAYER = 8,
    parameter int HIT_W  = 6,
    parameter int QUAL_W = 8,
    parameter int DEPTH  = 4,
    parameter int SEQ_W  = 8,
    parameter int OVF_W  = 8,
    localparam int CNT_W  = $clog2(NLAYER + 1),
    localparam int HITS_W = NLAYER * HIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_share_min,
    input  logic              in_valid,
    input  logic              in_eor,
    input  logic [HITS_W-1:0] in_hit,
    input  logic [NLAYER-1:0] in_present,
    input  logic [QUAL_W-1:0] in_chi,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_eor,
    output logic [HITS_W-1:0] out_hit,
    output logic [NLAYER-1:0] out_present,
    output logic [QUAL_W-1:0] out_chi,
    output logic [OVF_W-1:0]  drop_count
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    dedup_state_e state_q, state_d;

    logic [HITS_W-1:0]  buf_hit  [DEPTH];
    logic [NLAYER-1:0]  buf_pres [DEPTH];
    logic [QUAL_W-1:0]  buf_chi  [DEPTH];
    logic [DEPTH*SEQ_W-1:0] buf_seq;
    logic [DEPTH-1:0]   live;
    logic [SEQ_W-1:0]   seq_ctr;

    logic [DEPTH-1:0]   dup_vec, win_vec;
    logic               accept, any_dup, beats_all, have_free;
    logic [IDX_W-1:0]   free_idx, dup_idx, store_idx;
    logic               do_store, do_ovf;
    logic [DEPTH-1:0]   evict_mask;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;

    // One comparator per retained slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        trk_dedup_pair #(
            .NLAYER(NLAYER), .HIT_W(HIT_W), .QUAL_W(QUAL_W), .CNT_W(CNT_W)
        ) u_pair (
            .live      (live[g]),
            .old_hit   (buf_hit[g]),
            .old_pres  (buf_pres[g]),
            .old_chi   (buf_chi[g]),
            .new_hit   (in_hit),
            .new_pres  (in_present),
            .new_chi   (in_chi),
            .share_min (cfg_share_min),
            .is_dup    (dup_vec[g]),
            .new_better(win_vec[g])
        );
    end

    trk_dedup_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
        .live    (live),
        .seq_flat(buf_seq),
        .any     (pick_any),
        .idx     (pick_idx)
    );

    assign accept    = in_ready && in_valid;
    assign any_dup   = |dup_vec;
    assign beats_all = &(win_vec | ~dup_vec);
    assign have_free = ~&live;

    // Lowest free slot and lowest duplicate slot.
    always_comb begin
        free_idx = '0;
        dup_idx  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!live[i])   free_idx = IDX_W'(i);
            if (dup_vec[i]) dup_idx  = IDX_W'(i);
        end
    end

    // Keep / replace / discard decision for the offered candidate.
    always_comb begin
        do_store   = 1'b0;
        do_ovf     = 1'b0;
        store_idx  = free_idx;
        evict_mask = '0;
        if (accept) begin
            if (any_dup) begin
                if (beats_all) begin
                    evict_mask = dup_vec;
                    do_store   = 1'b1;
                    store_idx  = dup_idx;
                end
            end else if (have_free) begin
                do_store = 1'b1;
            end else begin
                do_ovf = 1'b1;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (in_eor)    state_d = ST_FLUSH;
            ST_FLUSH: if (!pick_any) state_d = ST_FILL;
            default:                 state_d = ST_FILL;
        endcase
    end

    // Outputs.
    always_comb begin
        in_ready    = 1'b0;
        out_valid   = 1'b0;
        out_eor     = 1'b0;
        out_hit     = buf_hit[pick_idx];
        out_present = buf_pres[pick_idx];
        out_chi     = buf_chi[pick_idx];
        unique case (state_q)
            ST_FILL:  in_ready = 1'b1;
            ST_FLUSH: begin
                out_valid = pick_any;
                out_eor   = !pick_any;
            end
            default: ;
        endcase
    end

    // Slot occupancy, arrival stamps, overflow counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live       <= '0;
            seq_ctr    <= '0;
            buf_seq    <= '0;
            drop_count <= '0;
        end else if (state_q == ST_FILL) begin
            live <= (live & ~evict_mask) |
                    (do_store ? (DEPTH'(1) << store_idx) : '0);
            if (do_store) buf_seq[store_idx*SEQ_W +: SEQ_W] <= seq_ctr;
            if (accept)   seq_ctr <= seq_ctr + SEQ_W'(1);
            if (do_ovf && (drop_count != '1)) drop_count <= drop_count + OVF_W'(1);
        end else begin
            if (pick_any) live[pick_idx] <= 1'b0;
            else          seq_ctr        <= '0;
        end
    end

    // Candidate payload storage.
    always_ff @(posedge clk) begin
        if (do_store) begin
            buf_hit[store_idx]  <= in_hit;
            buf_pres[store_idx] <= in_present;
            buf_chi[store_idx]  <= in_chi;
        end
    end

endmodule

// File: rtl/trk_dedup_chk.sv
module trk_dedup_chk #(
    parameter int OVF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             in_eor,
    input logic             out_valid,
    input logic             out_eor,
    input logic [OVF_W-1:0] drop_count
);

    AST_QUIET_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid && !out_eor));  // R7

    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_eor));  // R7

    AST_MARK_STOPS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_eor) |=> !in_ready);  // R7

    AST_EOR_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
        out_eor |=> (in_ready && !out_eor));  // R10

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == $past(drop_count)) ||
        (drop_count == OVF_W'($past(drop_count) + 1'b1)));  // R6

    AST_DROP_ONLY_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_ready) |-> $stable(drop_count));  // R6

endmodule

bind trk_dedup trk_dedup_chk #(.OVF_W(OVF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .in_eor    (in_eor),
    .out_valid (out_valid),
    .out_eor   (out_eor),
    .drop_count(drop_count)
);

// File: tb/trk_dedup_test.sv
module trk_dedup_test;

    localparam int CLK_PERIOD = 10;
    localparam int NLAYER = 8;
    localparam int HIT_W  = 6;
    localparam int QUAL_W = 8;
    localparam int DEPTH  = 4;
    localparam int OVF_W  = 8;
    localparam int CNT_W  = 4;
    localparam int NVEC   = 22;

    // {last, keep, present[7:0], hit nibbles[31:0] (layer l = nibble l), chi[7:0]}
    localparam logic [49:0] VEC [NVEC] = '{
        // road A: distinct, back to back (R3, R9)
        {1'b0, 1'b1, 8'hFF, 32'h11111111, 8'd20},
        {1'b0, 1'b1, 8'hFF, 32'h22222222, 8'd30},
        {1'b1, 1'b1, 8'hFF, 32'h33333333, 8'd10},
        // road B: chained replacement, order (R4, R7)
        {1'b0, 1'b0, 8'hFF, 32'h11111111, 8'd50},
        {1'b0, 1'b0, 8'hFF, 32'h11111122, 8'd40},
        {1'b0, 1'b1, 8'hFF, 32'h44444444, 8'd5},
        {1'b1, 1'b1, 8'hFF, 32'h11111133, 8'd30},
        // road C: tie and worse duplicate discarded (R5)
        {1'b0, 1'b1, 8'hFF, 32'h55555555, 8'd20},
        {1'b0, 1'b0, 8'hFF, 32'h55555566, 8'd20},
        {1'b1, 1'b0, 8'hFF, 32'h55555577, 8'd90},
        // road D: missing layers never shared (R2)
        {1'b0, 1'b1, 8'h0F, 32'h77777777, 8'd10},
        {1'b0, 1'b1, 8'hF0, 32'h77777777, 8'd5},
        {1'b1, 1'b1, 8'hFF, 32'h77777777, 8'd1},
        // road E: one candidate evicts two (R4)
        {1'b0, 1'b0, 8'hFF, 32'h88888888, 8'd40},
        {1'b0, 1'b0, 8'hFF, 32'h88889999, 8'd45},
        {1'b1, 1'b1, 8'hFF, 32'h88888899, 8'd30},
        // road F: full buffer drop, replacement while full (R6)
        {1'b0, 1'b0, 8'hFF, 32'hAAAAAAAA, 8'd50},
        {1'b0, 1'b1, 8'hFF, 32'hBBBBBBBB, 8'd50},
        {1'b0, 1'b1, 8'hFF, 32'hCCCCCCCC, 8'd50},
        {1'b0, 1'b1, 8'hFF, 32'hDDDDDDDD, 8'd50},
        {1'b0, 1'b0, 8'hFF, 32'hEEEEEEEE, 8'd50},
        {1'b1, 1'b1, 8'hFF, 32'hAAAAAAAB, 8'd10}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] cfg_share_min = CNT_W'(6);
    logic in_valid = 1'b0, in_eor = 1'b0;
    logic [NLAYER*HIT_W-1:0] in_hit = '0;
    logic [NLAYER-1:0] in_present = '0;
    logic [QUAL_W-1:0] in_chi = '0;
    logic in_ready, out_valid, out_eor;
    logic [NLAYER*HIT_W-1:0] out_hit;
    logic [NLAYER-1:0] out_present;
    logic [QUAL_W-1:0] out_chi;
    logic [OVF_W-1:0] drop_count;

    int n_chk = 0, n_bad = 0;
    logic [NLAYER*HIT_W-1:0] got_hit [16];
    logic [NLAYER-1:0] got_pres [16];
    logic [QUAL_W-1:0] got_chi [16];
    int got_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    trk_dedup uut (
        .clk(clk), .rst_n(rst_n), .cfg_share_min(cfg_share_min),
        .in_valid(in_valid), .in_eor(in_eor), .in_hit(in_hit),
        .in_present(in_present), .in_chi(in_chi), .in_ready(in_ready),
        .out_valid(out_valid), .out_eor(out_eor), .out_hit(out_hit),
        .out_present(out_present), .out_chi(out_chi), .drop_count(drop_count)
    );

    function automatic logic [NLAYER*HIT_W-1:0] widen(input logic [31:0] nib);
        logic [NLAYER*HIT_W-1:0] h = '0;
        for (int l = 0; l < NLAYER; l++) h[l*HIT_W +: HIT_W] = {2'b00, nib[l*4 +: 4]};
        return h;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Offer one input word at a negedge; returns at the following negedge.
    task automatic offer(input logic v, input logic e, input logic [7:0] pres,
                         input logic [31:0] nib, input logic [7:0] chi);
        in_valid = v; in_eor = e; in_present = pres; in_hit = widen(nib); in_chi = chi;
        @(negedge clk);
        in_valid = 1'b0; in_eor = 1'b0;
    endtask

    // Called at the negedge right after the marker edge; gathers the flush.
    task automatic collect(input string req);
        got_n = 0;
        check({req, " in_ready low in flush (R7)"}, 64'(in_ready), 64'd0);
        for (int c = 0; c < 32; c++) begin
            if (out_eor) begin
                check({req, " no data with marker (R7)"}, 64'(out_valid), 64'd0);
                return;
            end
            if (out_valid && got_n < 16) begin
                got_hit[got_n]  = out_hit;
                got_pres[got_n] = out_present;
                got_chi[got_n]  = out_chi;
                got_n++;
            end
            @(negedge clk);
        end
        check({req, " flush ended by marker (R7)"}, 64'd0, 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int road_start;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 in_ready", 64'(in_ready), 64'd1);
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 out_eor", 64'(out_eor), 64'd0);
        check("R1 drop_count", 64'(drop_count), 64'd0);

        // Table walk; the last candidate of each road carries the marker (R8).
        road_start = 0;
        for (int v = 0; v < NVEC; v++) begin
            offer(1'b1, VEC[v][49], VEC[v][47:40], VEC[v][39:8], VEC[v][7:0]);
            if (VEC[v][49]) begin
                collect("R7 table road");
                k = 0;
                for (int e = road_start; e <= v; e++) begin
                    if (VEC[e][48]) begin
                        if (k < got_n) begin
                            check("R3/R4/R5/R8 survivor chi in order", 64'(got_chi[k]), 64'(VEC[e][7:0]));
                            check("R2/R7 survivor hits", 64'(got_hit[k]), 64'(widen(VEC[e][39:8])));
                            check("R7 survivor mask", 64'(got_pres[k]), 64'(VEC[e][47:40]));
                        end
                        k++;
                    end
                end
                check("R9 survivor count", 64'(got_n), 64'(k));
                @(negedge clk);
                road_start = v + 1;
            end
        end
        check("R6 drop_count after full road", 64'(drop_count), 64'd1);

        // Threshold 4: four shared layers make a duplicate, the worse one goes (R2).
        cfg_share_min = CNT_W'(4);
        offer(1'b1, 1'b0, 8'hFF, 32'h88889999, 8'd10);
        offer(1'b1, 1'b1, 8'hFF, 32'h88888888, 8'd20);
        collect("R2 thr4");
        check("R2 thr4 count", 64'(got_n), 64'd1);
        check("R2 thr4 chi", 64'(got_chi[0]), 64'd10);
        @(negedge clk);

        // Threshold 8: the same pair is no longer a duplicate (R2).
        cfg_share_min = CNT_W'(8);
        offer(1'b1, 1'b0, 8'hFF, 32'h88889999, 8'd10);
        offer(1'b1, 1'b1, 8'hFF, 32'h88888888, 8'd20);
        collect("R2 thr8");
        check("R2 thr8 count", 64'(got_n), 64'd2);
        check("R2 thr8 second chi", 64'(got_chi[1]), 64'd20);
        @(negedge clk);

        // Input offered during flush is ignored (R7), next road is empty (R10).
        cfg_share_min = CNT_W'(6);
        offer(1'b1, 1'b1, 8'hFF, 32'h12121212, 8'd1);
        in_valid = 1'b1; in_eor = 1'b1; in_present = 8'hFF;
        in_hit = widen(32'h34343434); in_chi = 8'd2;
        collect("R7 busy");
        in_valid = 1'b0; in_eor = 1'b0;
        check("R7 busy count", 64'(got_n), 64'd1);
        check("R7 busy chi", 64'(got_chi[0]), 64'd1);
        @(negedge clk);
        check("R10 ready after marker", 64'(in_ready), 64'd1);
        offer(1'b0, 1'b1, 8'h00, 32'h0, 8'd0);
        collect("R10 empty road");
        check("R10 empty road count", 64'(got_n), 64'd0);
        @(negedge clk);
        check("R6 drop_count unchanged", 64'(drop_count), 64'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule